// File: doc/BRIEF.md
# Polled Channel Status Register Bank

This block gathers frame-error results for a large set of multiplexed channels and presents them to a processor as a small bank of packed 16-bit words that it can read over a simple strobed bus. A parity checker reports errored frames on one or more lanes, and each report names a channel. Errors set bits in a working vector while a frame is in progress. At every frame boundary the working vector is copied into a readable snapshot and then cleared. As a result, software that polls all status words once per frame period sees one coherent frame's worth of results. No interrupt is needed.

The same bus carries the opposite direction as well. Software writes one protection-select word for each group of sixteen channels, and the resulting vector drives the egress crossbar directly. A bit value of 1 steers that working channel onto its protection channel.

Top module: `polled_status_bank`

## Requirements
- R1: While reset is asserted and after it is released, every readable word reads as zero and `prot_sel_o` is all zero.
- R2: Channel n is reported in status word n/16, bit n%16. Status word k is read at address k (0 to 11), and protection word k is at address 16+k (16 to 27), bit n%16 controlling channel n.
- R3: An error reported during a frame is not visible in the status words until the next `frame_tick_i`. After that tick, each status bit is the OR of all errors reported for its channel during the frame just closed.
- R4: The working vector is cleared at each tick, so a snapshot holds only errors of the frame that tick closed, never those of earlier frames.
- R5: An error reported in the same cycle as `frame_tick_i` is counted in the new frame: it is absent from the snapshot taken at that tick and present in the next one.
- R6: Both error lanes are accepted in the same cycle, whether they name the same channel or two different channels.
- R7: Read data appears on `bus_rdata_o` exactly one cycle after `bus_rd_i` is sampled high. In any cycle following one with `bus_rd_i` low, `bus_rdata_o` is zero.
- R8: A read of any address outside 0–11 and 16–27 returns zero.
- R9: A write to address 16+k loads `bus_wdata_i` into protection word k, visible on `prot_sel_o` and in read-back from the cycle after the write. Bit value 1 selects the protection channel.
- R10: Writes to status addresses 0–11 and to unmapped addresses change neither `prot_sel_o` nor any readable word.
- R11: An error report naming a channel number of 192 or above is ignored.
- R12: The snapshot holds between ticks. A read sampled in the same cycle as a tick returns the snapshot that existed before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_vld_i | input | 2 | Per-lane error report valid |
| err_ch_i | input | 16 | Per-lane channel number, 8 bits per lane, lane 0 in the low byte |
| frame_tick_i | input | 1 | Frame boundary pulse; snapshot copy and working clear |
| bus_addr_i | input | 16 | Word address shared by read and write |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| prot_sel_o | output | 192 | Per-channel protection select to the crossbar |

## Verification
Every result of this block is due one edge after its cause. Read data answers a strobe one cycle later. A snapshot reflects errors up to and including the cycle before the tick, and a switch write shows on `prot_sel_o` after the edge that samples it. The bench drives all inputs on the falling edge. It computes each expected read value from its own model before the rising edge, updates the model at that edge, and compares at the following falling edge. This way, reads that coincide with ticks, writes or errors are checked against the state that preceded the edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_STAT = 2'd1,
    RGN_SW   = 2'd2
  } region_e;
endpackage

// File: rtl/pcs_addr_decode.sv
module pcs_addr_decode
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_WORDS = 12,
  parameter int IDX_W     = 4,
  parameter int STAT_BASE = 0,
  parameter int SW_BASE   = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(STAT_BASE + NUM_WORDS);
  localparam logic [ADDR_W-1:0] SW_LO   = ADDR_W'(SW_BASE);
  localparam logic [ADDR_W-1:0] SW_HI   = ADDR_W'(SW_BASE + NUM_WORDS);

  logic [ADDR_W-1:0] stat_off, sw_off;
  assign stat_off = addr_i - STAT_LO;
  assign sw_off   = addr_i - SW_LO;

  always_comb begin
    region_o = RGN_NONE;
    idx_o    = '0;
    if (addr_i >= STAT_LO && addr_i < STAT_HI) begin
      region_o = RGN_STAT;
      idx_o    = stat_off[IDX_W-1:0];
    end else if (addr_i >= SW_LO && addr_i < SW_HI) begin
      region_o = RGN_SW;
      idx_o    = sw_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/pcs_err_accum.sv
module pcs_err_accum #(
  parameter int NUM_CH = 192,
  parameter int LANES  = 2,
  parameter int CH_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LANES-1:0]      err_vld_i,
  input  logic [LANES*CH_W-1:0] err_ch_i,
  input  logic                  frame_tick_i,
  output logic [NUM_CH-1:0]     snap_o
);
  logic [NUM_CH-1:0] hit, work_q, snap_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [LANES-1:0] lane_hit;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_hit[l] = err_vld_i[l] && (err_ch_i[l*CH_W +: CH_W] == CH_W'(n));
    end
    assign hit[n] = |lane_hit;
  end

  // errors seen on the tick cycle start the new frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      snap_q <= '0;
    end else if (frame_tick_i) begin
      snap_q <= work_q;
      work_q <= hit;
    end else begin
      work_q <= work_q | hit;
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/pcs_switch_regs.sv
module pcs_switch_regs #(
  parameter int NUM_WORDS = 12,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_WORDS*DATA_W-1:0] sel_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '0;
      else if (wr_en_i && idx_i == IDX_W'(w))   word_q <= wdata_i;
    end
    assign sel_o[w*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/pcs_read_mux.sv
module pcs_read_mux
  import pcs_pkg::*;
#(
  parameter int NUM_WORDS = 12,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  region_e                     region_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [NUM_WORDS*DATA_W-1:0] stat_i,
  input  logic [NUM_WORDS*DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] stat_word, sw_word, rd_word;

  always_comb begin
    stat_word = '0;
    sw_word   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx_i == IDX_W'(w)) begin
        stat_word = stat_i[w*DATA_W +: DATA_W];
        sw_word   = sw_i[w*DATA_W +: DATA_W];
      end
    end
    unique case (region_i)
      RGN_STAT: rd_word = stat_word;
      RGN_SW:   rd_word = sw_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_word;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/polled_status_bank.sv
module polled_status_bank
  import pcs_pkg::*;
#(
  parameter int NUM_CH    = 192,
  parameter int LANES     = 2,
  parameter int CH_W      = $clog2(NUM_CH),
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STAT_BASE = 0,
  parameter int SW_BASE   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LANES-1:0]      err_vld_i,
  input  logic [LANES*CH_W-1:0] err_ch_i,
  input  logic                  frame_tick_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic                  bus_rd_i,
  input  logic                  bus_wr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic [NUM_CH-1:0]     prot_sel_o
);
  localparam int NUM_WORDS = NUM_CH / DATA_W;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  region_e                     region;
  logic [IDX_W-1:0]            idx;
  logic [NUM_CH-1:0]           snap;
  logic [NUM_WORDS*DATA_W-1:0] sw_sel;

  pcs_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
    .STAT_BASE(STAT_BASE), .SW_BASE(SW_BASE)
  ) u_dec (
    .addr_i(bus_addr_i), .region_o(region), .idx_o(idx)
  );

  pcs_err_accum #(.NUM_CH(NUM_CH), .LANES(LANES), .CH_W(CH_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_vld_i(err_vld_i), .err_ch_i(err_ch_i),
    .frame_tick_i(frame_tick_i), .snap_o(snap)
  );

  pcs_switch_regs #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(bus_wr_i && region == RGN_SW),
    .idx_i(idx), .wdata_i(bus_wdata_i), .sel_o(sw_sel)
  );

  pcs_read_mux #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(bus_rd_i), .region_i(region), .idx_i(idx),
    .stat_i(snap), .sw_i(sw_sel), .rdata_o(bus_rdata_o)
  );

  assign prot_sel_o = sw_sel;
endmodule

// File: rtl/polled_status_bank_chk.sv
module polled_status_bank_chk #(
  parameter int NUM_CH    = 192,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STAT_BASE = 0,
  parameter int SW_BASE   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_tick_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [NUM_CH-1:0] prot_sel_o,
  input logic [NUM_CH-1:0] snap_i
);
  localparam int NUM_WORDS = NUM_CH / DATA_W;

  int unsigned a;
  logic stat_hit, sw_hit;
  logic [DATA_W-1:0] stat_word;
  assign a        = 32'(bus_addr_i);
  assign stat_hit = a >= STAT_BASE && a < STAT_BASE + NUM_WORDS;
  assign sw_hit   = a >= SW_BASE && a < SW_BASE + NUM_WORDS;

  always_comb begin
    stat_word = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (a == 32'(STAT_BASE + w)) stat_word = snap_i[w*DATA_W +: DATA_W];
  end

  logic              wr_q;
  int unsigned       wi_q;
  logic [DATA_W-1:0] wd_q, sw_pick;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0; wi_q <= 0; wd_q <= '0;
    end else begin
      wr_q <= bus_wr_i && sw_hit;
      wi_q <= a - SW_BASE;
      wd_q <= bus_wdata_i;
    end
  end
  always_comb begin
    sw_pick = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (wi_q == 32'(w)) sw_pick = prot_sel_o[w*DATA_W +: DATA_W];
  end

  assert_rd_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == '0);
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && !stat_hit && !sw_hit |=> bus_rdata_o == '0);
  assert_stat_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && stat_hit |=> bus_rdata_o == $past(stat_word));
  assert_sw_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && sw_hit) |=> $stable(prot_sel_o));
  assert_sw_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> sw_pick == wd_q);
  assert_snap_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(snap_i));
endmodule

bind polled_status_bank polled_status_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STAT_BASE(STAT_BASE), .SW_BASE(SW_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_tick_i(frame_tick_i),
  .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .prot_sel_o(prot_sel_o), .snap_i(snap)
);

// File: tb/polled_status_bank_tb.sv
module polled_status_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 192;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  err_vld_i = '0;
  logic [15:0] err_ch_i = '0;
  logic        frame_tick_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [NCH-1:0] prot_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [NCH-1:0] m_work = '0, m_snap = '0, m_sw = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  polled_status_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_vld_i(err_vld_i), .err_ch_i(err_ch_i),
    .frame_tick_i(frame_tick_i), .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .prot_sel_o(prot_sel_o)
  );

  function automatic logic [15:0] exp_read(input logic [15:0] addr);
    int a = int'(addr);
    if (a < 12) return m_snap[a*16 +: 16];
    if (a >= 16 && a < 28) return m_sw[(a-16)*16 +: 16];
    return 16'h0;
  endfunction

  function automatic logic is_sw(input logic [15:0] addr);
    return addr >= 16'd16 && addr < 16'd28;
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s rdata act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_sel(input string tag);
    n_chk++;
    if (prot_sel_o !== m_sw) begin
      n_bad++;
      $display("FAIL %s prot_sel act=%h exp=%h t=%0t", tag, prot_sel_o, m_sw, $time);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input logic [1:0] ev, input logic [7:0] c0, input logic [7:0] c1,
                     input logic tick, input logic rd, input logic wr,
                     input logic [15:0] addr, input logic [15:0] wd, input string tag);
    logic [15:0] exp_rd;
    logic [NCH-1:0] hits;
    string t;
    err_vld_i = ev; err_ch_i = {c1, c0}; frame_tick_i = tick;
    bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
    exp_rd = rd ? exp_read(addr) : 16'h0;
    hits = '0;
    if (ev[0] && int'(c0) < NCH) hits[c0] = 1'b1;   // R11: out-of-range ignored
    if (ev[1] && int'(c1) < NCH) hits[c1] = 1'b1;
    @(posedge clk_i);
    if (tick) begin m_snap = m_work; m_work = hits; end
    else m_work = m_work | hits;
    if (wr && is_sw(addr)) m_sw[(int'(addr)-16)*16 +: 16] = wd;
    @(negedge clk_i);
    if (!rd) t = "R7";
    else if (exp_read(16'(0)) === 16'hx) t = tag;
    else if (!(addr < 16'd12) && !is_sw(addr)) t = "R8";
    else t = tag;
    check16(t, bus_rdata_o, exp_rd);
    check_sel((wr && is_sw(addr)) ? "R9" : "R10");
    err_vld_i = '0; frame_tick_i = 1'b0; bus_rd_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic idle();
    cyc(2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "R7");
  endtask
  task automatic err1(input int ch);
    cyc(2'b01, 8'(ch), 8'd0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "R3");
  endtask
  task automatic tick();
    cyc(2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 16'd0, 16'd0, "R3");
  endtask
  task automatic rd_at(input logic [15:0] addr, input string tag);
    cyc(2'b00, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0, addr, 16'd0, tag);
  endtask
  task automatic wr_at(input logic [15:0] addr, input logic [15:0] d);
    cyc(2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, addr, d, "R10");
  endtask
  task automatic rd_all(input string tag);
    for (int k = 0; k < 12; k++) rd_at(16'(k), tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1: outputs zero during reset
    check16("R1", bus_rdata_o, 16'h0);
    check_sel("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 32; k++) rd_at(16'(k), "R1");

    // R2 mapping, R3 visibility after tick only
    err1(0); err1(15); err1(16); err1(191);
    rd_at(16'd0, "R3"); rd_at(16'd11, "R3");
    tick();
    rd_at(16'd0, "R2"); rd_at(16'd1, "R2"); rd_at(16'd11, "R2");
    check16("R2", exp_read(16'd0), 16'h8001);
    check16("R2", exp_read(16'd11), 16'h8000);

    // R4: previous frame cleared; R5: error on tick cycle goes to new frame
    err1(33);
    cyc(2'b01, 8'd5, 8'd0, 1'b1, 1'b0, 1'b0, 16'd0, 16'd0, "R5");
    rd_all("R4");
    tick();
    rd_at(16'd0, "R5");
    check16("R5", exp_read(16'd0), 16'h0020);
    rd_at(16'd2, "R4");

    // R6: two lanes same cycle, different and equal channels
    cyc(2'b11, 8'd40, 8'd100, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "R6");
    cyc(2'b11, 8'd77, 8'd77, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "R6");
    tick();
    rd_all("R6");

    // R11: channel numbers 192 and up ignored
    cyc(2'b11, 8'd192, 8'd255, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "R11");
    err1(200);
    tick();
    rd_all("R11");

    // R12: read sampled on the tick cycle returns old snapshot
    err1(3);
    tick();
    err1(20);
    cyc(2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 1'b0, 16'd0, 16'd0, "R12");
    cyc(2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 1'b0, 16'd1, 16'd0, "R12");
    rd_at(16'd0, "R12");

    // R8: unmapped reads
    rd_at(16'd12, "R8"); rd_at(16'd15, "R8"); rd_at(16'd28, "R8"); rd_at(16'hFFFF, "R8");

    // R9 switch writes and readback
    wr_at(16'd16, 16'hA5A5);
    wr_at(16'd27, 16'h8001);
    rd_at(16'd16, "R9"); rd_at(16'd27, "R9");
    n_chk++;
    if (prot_sel_o[191] !== 1'b1 || prot_sel_o[176] !== 1'b1 || prot_sel_o[1] !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 bit select act=%b%b%b exp=110", prot_sel_o[191], prot_sel_o[176], prot_sel_o[1]);
    end

    // R10: writes to status and unmapped addresses ignored
    wr_at(16'd0, 16'hFFFF); wr_at(16'd12, 16'hFFFF); wr_at(16'd28, 16'hFFFF); wr_at(16'h8010, 16'hFFFF);
    rd_all("R10");
    for (int k = 16; k < 28; k++) rd_at(16'(k), "R10");

    // random traffic
    for (int f = 0; f < 30; f++) begin
      for (int c = 0; c < 40; c++) begin
        logic [1:0] ev;
        logic [15:0] ad;
        ev[0] = ($urandom % 6) == 0;
        ev[1] = ($urandom % 6) == 0;
        ad = (($urandom % 16) == 0) ? 16'($urandom) : 16'($urandom % 32);
        cyc(ev, 8'($urandom % 200), 8'($urandom % 200), c == 39,
            ($urandom % 2) == 0, ($urandom % 12) == 0, ad, 16'($urandom), "R3");
      end
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule